// File: doc/BRIEF.md
# Integer Add, Negate and Power-of-Two Shift Unit

This unit performs the cheap integer operations a datapath needs on W-bit words: a modular addition that reports the unsigned carry and, as two separate flags, signed overflow in either direction. It also negates a word as complement-plus-one, and scales a word by 2^k with shifts. A right scale by 2^k is an exact division for unsigned words. For signed words it rounds toward zero: negative dividends receive a 2^k-1 bias before the arithmetic shift, so a remainder never pulls the quotient toward minus infinity.

All outputs come from one register stage. Operands, shift amount, signedness and operation code are sampled at a rising clock edge, and the result and flags for them are visible after that edge. The flags describe the addition only and read zero for every other operation.

Top module: `arith_shift_unit`

## Requirements
- R1: While the active-low reset is asserted, the result and all three flags read zero.
- R2: Inputs sampled at a rising edge produce their result after exactly that edge; the outputs keep their previous value until then.
- R3: With op_sel = 2'b00 (add), the result is (op_a + op_b) mod 2^W and carry_out is bit W of the true unsigned sum, whatever is_signed holds.
- R4: On an add, pos_ovf is 1 exactly when both operands have bit W-1 clear and the result has bit W-1 set.
- R5: On an add, neg_ovf is 1 exactly when both operands have bit W-1 set and the result has bit W-1 clear.
- R6: With op_sel = 2'b01 (negate), the result is ~op_a + 1 and op_b is ignored; the most negative value and zero map to themselves.
- R7: With op_sel = 2'b10 (left scale), the result is op_a shifted left by shamt with bits beyond W dropped, the same for both signedness settings; shamt = 0 passes op_a through and shamt >= W gives zero.
- R8: With op_sel = 2'b11 (right scale) and is_signed = 0, the result is the logical right shift of op_a by shamt; shamt >= W gives zero.
- R9: A right scale with is_signed = 1 and bit W-1 of op_a clear gives the same value as the logical shift.
- R10: A right scale with is_signed = 1 and a negative op_a gives op_a / 2^shamt rounded toward zero: the arithmetic shift when the low shamt bits are zero, one more than it otherwise; shamt >= W gives zero, and the most negative value scaled by 2^(W-1) gives -1.
- R11: For every operation other than add, carry_out, pos_ovf and neg_ovf read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_sel | input | 2 | 00 add, 01 negate, 10 left scale, 11 right scale |
| is_signed | input | 1 | Right scale treats op_a as two's complement when 1 |
| op_a | input | W | First operand, dividend or value to negate/scale |
| op_b | input | W | Second addend |
| shamt | input | SW | Power-of-two exponent k |
| result | output | W | Registered result |
| carry_out | output | 1 | Unsigned carry of the add |
| pos_ovf | output | 1 | Signed add wrapped past the positive limit |
| neg_ovf | output | 1 | Signed add wrapped past the negative limit |

## Verification
Additions are tried with pairs that give no carry, an unsigned carry without signed wrap, a positive wrap and two negative wraps, which separates the three flags from one another. Right scales of negative dividends are tried both with remainder-free values and with non-zero low bits, and a sweep over small dividends and exponents compares against integer division that truncates, which tells the biased rounding apart from a plain arithmetic shift. Shift amounts of zero, W-1, W and beyond W check the clamping edges, and negate and shift operations with overflow-prone operands show the flags stay clear.

// File: rtl/asu_pkg.sv
package asu_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_NEG = 2'b01,
    OP_SHL = 2'b10,
    OP_SHR = 2'b11
  } asu_op_e;
endpackage

// File: rtl/asu_add_stage.sv
module asu_add_stage #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         carry,
  output logic         pos_wrap,
  output logic         neg_wrap
);
  // True sum in W+1 bits; top bit is the carry that the modular sum drops.
  function automatic logic [W:0] wide_sum(input logic [W-1:0] x, input logic [W-1:0] y);
    return {1'b0, x} + {1'b0, y};
  endfunction

  logic [W:0] full;
  logic       a_neg, b_neg, s_neg;

  assign full     = wide_sum(a, b);
  assign sum      = full[W-1:0];
  assign carry    = full[W];
  assign a_neg    = a[W-1];
  assign b_neg    = b[W-1];
  assign s_neg    = full[W-1];
  assign pos_wrap = !a_neg && !b_neg &&  s_neg;
  assign neg_wrap =  a_neg &&  b_neg && !s_neg;
endmodule

// File: rtl/asu_neg_stage.sv
module asu_neg_stage #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  output logic [W-1:0] neg
);
  function automatic logic [W-1:0] twos_neg(input logic [W-1:0] x);
    return (~x) + W'(1);
  endfunction

  assign neg = twos_neg(a);
endmodule

// File: rtl/asu_shift_stage.sv
module asu_shift_stage #(
  parameter int W  = 16,
  parameter int SW = $clog2(W) + 1
) (
  input  logic [W-1:0]  a,
  input  logic [SW-1:0] k,
  input  logic          is_signed,
  output logic [W-1:0]  shl_res,
  output logic [W-1:0]  shr_res,
  output logic          bias_taken
);
  localparam int KW = $clog2(W + 1);

  // Amounts of W or more behave like W.
  function automatic logic [KW-1:0] clamp_k(input logic [SW-1:0] kin);
    if (int'(kin) >= W) return KW'(W);
    return KW'(kin);
  endfunction

  function automatic logic [W:0] bias_of(input logic [KW-1:0] ke);
    return ((W+1)'(1) << ke) - (W+1)'(1);
  endfunction

  function automatic logic [W-1:0] scale_up(input logic [W-1:0] x, input logic [KW-1:0] ke);
    return x << ke;
  endfunction

  // Dividend widened by one bit so the bias never overflows.
  function automatic logic [W-1:0] scale_down(input logic [W-1:0] x, input logic [KW-1:0] ke,
                                              input logic sgn);
    logic signed [W:0] ext;
    logic signed [W:0] q;
    logic              neg;
    neg = sgn && x[W-1];
    ext = $signed({neg, x});
    if (neg) ext = ext + $signed(bias_of(ke));
    q = ext >>> ke;
    return q[W-1:0];
  endfunction

  logic [KW-1:0] k_eff;
  logic [W:0]    low_mask;
  logic          dividend_neg;

  assign k_eff        = clamp_k(k);
  assign low_mask     = bias_of(k_eff);
  assign dividend_neg = is_signed && a[W-1];
  assign bias_taken   = dividend_neg && ((a & low_mask[W-1:0]) != '0);
  assign shl_res      = scale_up(a, k_eff);
  assign shr_res      = scale_down(a, k_eff, is_signed);
endmodule

// File: rtl/arith_shift_unit.sv
module arith_shift_unit #(
  parameter int W  = 16,
  parameter int SW = $clog2(W) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    op_sel,
  input  logic          is_signed,
  input  logic [W-1:0]  op_a,
  input  logic [W-1:0]  op_b,
  input  logic [SW-1:0] shamt,
  output logic [W-1:0]  result,
  output logic          carry_out,
  output logic          pos_ovf,
  output logic          neg_ovf
);
  import asu_pkg::*;

  asu_op_e     op;
  logic [W-1:0] sum_w, neg_w, shl_w, shr_w;
  logic         carry_w, pos_w, negw_w;
  logic         bias_taken;
  logic [W-1:0] res_d;
  logic         c_d, p_d, n_d;

  assign op = asu_op_e'(op_sel);

  asu_add_stage #(.W(W)) u_add (
    .a(op_a), .b(op_b), .sum(sum_w), .carry(carry_w),
    .pos_wrap(pos_w), .neg_wrap(negw_w)
  );

  asu_neg_stage #(.W(W)) u_neg (
    .a(op_a), .neg(neg_w)
  );

  asu_shift_stage #(.W(W), .SW(SW)) u_shift (
    .a(op_a), .k(shamt), .is_signed(is_signed),
    .shl_res(shl_w), .shr_res(shr_w), .bias_taken(bias_taken)
  );

  always_comb begin
    res_d = '0;
    c_d   = 1'b0;
    p_d   = 1'b0;
    n_d   = 1'b0;
    unique case (op)
      OP_ADD: begin
        res_d = sum_w;
        c_d   = carry_w;
        p_d   = pos_w;
        n_d   = negw_w;
      end
      OP_NEG: res_d = neg_w;
      OP_SHL: res_d = shl_w;
      OP_SHR: res_d = shr_w;
      default: res_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result    <= '0;
      carry_out <= 1'b0;
      pos_ovf   <= 1'b0;
      neg_ovf   <= 1'b0;
    end else begin
      result    <= res_d;
      carry_out <= c_d;
      pos_ovf   <= p_d;
      neg_ovf   <= n_d;
    end
  end
endmodule

// File: rtl/asu_checker.sv
module asu_checker #(
  parameter int W  = 16,
  parameter int SW = $clog2(W) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    op_sel,
  input logic          is_signed,
  input logic [W-1:0]  op_a,
  input logic [W-1:0]  op_b,
  input logic [SW-1:0] shamt,
  input logic [W-1:0]  result,
  input logic          carry_out,
  input logic          pos_ovf,
  input logic          neg_ovf,
  input logic          bias_taken
);
  import asu_pkg::*;

  p_flags_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(pos_ovf && neg_ovf));

  p_pos_ovf_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OP_ADD && !op_a[W-1] && !op_b[W-1]) |=> (pos_ovf == result[W-1]));

  p_neg_ovf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OP_ADD && op_a[W-1] && op_b[W-1]) |=> (neg_ovf == !result[W-1]));

  p_no_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel != OP_ADD) |=> (!carry_out && !pos_ovf && !neg_ovf));

  p_negate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OP_NEG) |=> (W'(result + $past(op_a)) == '0));

  p_shl_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OP_SHL && shamt == '0) |=> (result == $past(op_a)));

  p_shr_pos_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OP_SHR && is_signed && !op_a[W-1]) |=> !result[W-1]);

  p_round_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OP_SHR && bias_taken) |=> (result != $past(op_a)));
endmodule

bind arith_shift_unit asu_checker #(.W(W), .SW(SW)) u_asu_chk (
  .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .is_signed(is_signed),
  .op_a(op_a), .op_b(op_b), .shamt(shamt), .result(result),
  .carry_out(carry_out), .pos_ovf(pos_ovf), .neg_ovf(neg_ovf),
  .bias_taken(bias_taken)
);

// File: tb/arith_shift_unit_bench.sv
module arith_shift_unit_bench;
  localparam int W  = 16;
  localparam int SW = 5;
  localparam int NV = 21;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    op_sel = 2'b00;
  logic          is_signed = 1'b0;
  logic [W-1:0]  op_a = 16'hA5A5;
  logic [W-1:0]  op_b = 16'h5A5A;
  logic [SW-1:0] shamt = 5'd3;
  logic [W-1:0]  result;
  logic          carry_out, pos_ovf, neg_ovf;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  arith_shift_unit #(.W(W), .SW(SW)) u_arith_shift_unit (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .is_signed(is_signed),
    .op_a(op_a), .op_b(op_b), .shamt(shamt), .result(result),
    .carry_out(carry_out), .pos_ovf(pos_ovf), .neg_ovf(neg_ovf)
  );

  // {req[3:0], op[1:0], sgn, a[15:0], b[15:0], k[4:0], res[15:0], c, p, n}
  localparam logic [62:0] VEC [NV] = '{
    {4'd3,  2'd0, 1'b0, 16'h0001, 16'h0002, 5'd0,  16'h0003, 3'b000},
    {4'd3,  2'd0, 1'b0, 16'hFFFF, 16'h0001, 5'd0,  16'h0000, 3'b100},
    {4'd4,  2'd0, 1'b0, 16'h7FFF, 16'h0001, 5'd0,  16'h8000, 3'b010},
    {4'd5,  2'd0, 1'b0, 16'h8000, 16'h8000, 5'd0,  16'h0000, 3'b101},
    {4'd5,  2'd0, 1'b1, 16'h8000, 16'hFFFF, 5'd0,  16'h7FFF, 3'b101},
    {4'd6,  2'd1, 1'b0, 16'h0005, 16'h1234, 5'd0,  16'hFFFB, 3'b000},
    {4'd6,  2'd1, 1'b1, 16'h8000, 16'h8000, 5'd0,  16'h8000, 3'b000},
    {4'd6,  2'd1, 1'b0, 16'h0000, 16'hFFFF, 5'd0,  16'h0000, 3'b000},
    {4'd7,  2'd2, 1'b0, 16'h1234, 16'h0000, 5'd4,  16'h2340, 3'b000},
    {4'd7,  2'd2, 1'b1, 16'h8001, 16'h0000, 5'd0,  16'h8001, 3'b000},
    {4'd7,  2'd2, 1'b0, 16'hFFFF, 16'h0000, 5'd20, 16'h0000, 3'b000},
    {4'd8,  2'd3, 1'b0, 16'h8000, 16'h0000, 5'd15, 16'h0001, 3'b000},
    {4'd8,  2'd3, 1'b0, 16'hF000, 16'h0000, 5'd16, 16'h0000, 3'b000},
    {4'd9,  2'd3, 1'b1, 16'h7FFF, 16'h0000, 5'd3,  16'h0FFF, 3'b000},
    {4'd10, 2'd3, 1'b1, 16'hFFF9, 16'h0000, 5'd1,  16'hFFFD, 3'b000},
    {4'd10, 2'd3, 1'b1, 16'hFFF8, 16'h0000, 5'd3,  16'hFFFF, 3'b000},
    {4'd10, 2'd3, 1'b1, 16'hFFF9, 16'h0000, 5'd3,  16'h0000, 3'b000},
    {4'd10, 2'd3, 1'b1, 16'h8000, 16'h0000, 5'd15, 16'hFFFF, 3'b000},
    {4'd10, 2'd3, 1'b1, 16'h8000, 16'h0000, 5'd31, 16'h0000, 3'b000},
    {4'd7,  2'd2, 1'b1, 16'h8001, 16'h8001, 5'd1,  16'h0002, 3'b000},
    {4'd4,  2'd0, 1'b1, 16'h7FFF, 16'h0001, 5'd0,  16'h8000, 3'b010}
  };

  function automatic string tag(input int r);
    case (r)
      1: return "R1";   2: return "R2";   3: return "R3";
      4: return "R4";   5: return "R5";   6: return "R6";
      7: return "R7";   8: return "R8";   9: return "R9";
      10: return "R10"; default: return "R11";
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] op, input logic sg, input logic [W-1:0] a,
                       input logic [W-1:0] b, input logic [SW-1:0] k);
    @(negedge clk);
    op_sel = op; is_signed = sg; op_a = a; op_b = b; shamt = k;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R1: outputs held at zero under reset with busy inputs
    repeat (3) @(posedge clk);
    #1;
    check("R1", "result in reset", result, '0);
    check("R1", "flags in reset", {13'd0, carry_out, pos_ovf, neg_ovf}, '0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [62:0] v;
      int          r;
      v = VEC[i];
      r = int'(v[62:59]);
      apply(v[58:57], v[56], v[55:40], v[39:24], v[23:19]);
      check(tag(r), $sformatf("row %0d result", i), result, v[18:3]);
      check((v[58:57] == 2'd0) ? tag(r) : "R11", $sformatf("row %0d flags", i),
            {13'd0, carry_out, pos_ovf, neg_ovf}, {13'd0, v[2:0]});
    end

    // R2: new inputs do not reach the outputs before the capturing edge
    apply(2'd0, 1'b0, 16'h0010, 16'h0020, 5'd0);
    @(negedge clk);
    op_sel = 2'd0; op_a = 16'h0100; op_b = 16'h0200;
    #1;
    check("R2", "before edge", result, 16'h0030);
    @(posedge clk);
    #1;
    check("R2", "after edge", result, 16'h0300);

    // R10 / R9 / R8: sweep against truncating integer division and plain shifts
    for (int a = -50; a <= 50; a += 7) begin
      for (int k = 0; k <= 6; k++) begin
        int q;
        q = a / (1 << k);
        apply(2'd3, 1'b1, W'(a), 16'h0000, SW'(k));
        check(a < 0 ? "R10" : "R9", $sformatf("signed %0d/2^%0d", a, k), result, W'(q));
        apply(2'd3, 1'b0, W'(a), 16'h0000, SW'(k));
        check("R8", $sformatf("unsigned %0d>>%0d", a, k), result, W'(a) >> k);
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule